// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This unit sits beside a small CPU core and decides which of five interrupt requests, if any, is taken at each instruction boundary. One request is non-maskable and needs a fresh rising edge with the line still high. One maskable request is edge-latched, so a short pulse is remembered until it is serviced or cleared. Two maskable requests are level-sensitive. The last is a non-vectored request, for which the device itself supplies the opcode. A global enable flag gates every maskable source. Three individual mask bits gate the vectored maskable sources.

The core pulses `boundary` once per instruction. On that clock edge the unit picks a single winner by fixed priority. On the next cycle it raises `take_o` for one cycle, together with a 16-bit vector address, or with `ext_ack_o` when the winner is the non-vectored source. The core programs the unit through an 8-bit configuration write. It observes masks, enable, pending and pin state through an 8-bit status read. A serial-output bit is held in a register; serial pin timing is left to other logic.

Top module: `irqc_top`

## Requirements
- R1: After reset, `status_o` bits 2:0 read 1 (all masks set), bit 3 reads 0 (enable clear), bit 6 reads 0 (no latched edge), `take_o` is 0 and `ser_out_o` is 0.
- R2: A non-maskable request is taken regardless of the enable flag and the masks. It yields vector 0x0024 with `take_o` high in the cycle after the `boundary` edge, for exactly one cycle.
- R3: The non-maskable request is recognized only if a rising edge has occurred and the line is still high at `boundary`. It is not taken again until the line goes low and then high.
- R4: When several sources are eligible, exactly one is taken, in the order: non-maskable, edge-latched, mid level, low level, non-vectored. With no eligible source, a `boundary` produces no take.
- R5: Vectors are 0x003C for the edge-latched source, 0x0034 for the mid level source and 0x002C for the low level source. `ext_ack_o` is 0 for all of them.
- R6: A taken non-vectored request drives `ext_ack_o`=1 with vector 0x0000.
- R7: A rising edge on `edge_line` sets a pending latch (status bit 6), even while that source is masked. The latch stays set after the line drops and clears when the source is taken. A held-high line does not set it again.
- R8: A configuration write with bit 4 set clears the edge pending latch.
- R9: The mid and low level sources are taken only if their line is high at the `boundary` edge.
- R10: In a configuration write, bits 0, 1 and 2 mask the low, mid and edge-latched sources (1 = masked). They are applied only when bit 3 is 1; otherwise the masks are unchanged.
- R11: `ei_stb` sets the enable flag and `di_stb` clears it. Taking any maskable source clears it. While it is clear, no maskable source is taken.
- R12: In a configuration write with bit 6 set, bit 7 is copied to `ser_out_o`. With bit 6 clear, `ser_out_o` keeps its value.
- R13: `status_o` reads, from bit 7 down: the `ser_in` pin, the edge pending latch, the live mid line, the live low line, the enable flag, then the masks for the edge-latched, mid and low sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_line | input | 1 | Non-maskable request line |
| edge_line | input | 1 | Edge-latched maskable request line |
| lvl_mid | input | 1 | Level-sensitive maskable request, middle priority |
| lvl_lo | input | 1 | Level-sensitive maskable request, lower priority |
| ext_line | input | 1 | Non-vectored maskable request |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| ei_stb | input | 1 | Set the global enable flag |
| di_stb | input | 1 | Clear the global enable flag |
| mwr_en | input | 1 | Configuration write strobe |
| mwr_data | input | 8 | Configuration write data |
| ser_in | input | 1 | Serial input pin, reflected in status |
| status_o | output | 8 | Status read value |
| take_o | output | 1 | One-cycle pulse: an interrupt was accepted |
| vec_o | output | 16 | Vector address of the accepted interrupt |
| ext_ack_o | output | 1 | Accepted interrupt is non-vectored; the device supplies the opcode |
| ser_out_o | output | 1 | Registered serial output bit |

## Verification
The main function is driven from a table of request mixes. Each row sets masks and the enable flag and raises a chosen subset of the five lines. Rows with nested subsets separate each priority rank from the next, and rows with one source masked or the enable flag clear separate mask gating from priority. Directed sequences then exercise the trigger types: a held non-maskable line, a pulse that ends before the strobe, a masked edge that is remembered and then taken when unmasked, the clear-on-write path, and serial-bit writes with and without their qualifier.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CFG_W = 8;
  localparam int SRC_N = 5;
  localparam int MSK_N = 3;

  // configuration-write bit positions (software-visible encoding)
  localparam int MW_MSK_EN = 3;
  localparam int MW_PCLR   = 4;
  localparam int MW_SOE    = 6;
  localparam int MW_SOD    = 7;

  // priority order: lower index wins
  typedef enum logic [2:0] {
    SRC_NMI = 3'd0,
    SRC_HI  = 3'd1,
    SRC_MID = 3'd2,
    SRC_LO  = 3'd3,
    SRC_EXT = 3'd4
  } src_e;
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
  parameter bit HOLD_LEVEL = 1'b0  // 1: pending drops when the line drops
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise = line_i & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_hold
      assign pend_d = clr_i ? 1'b0 : ((pend_q | rise) & line_i);
    end else begin : g_keep
      assign pend_d = clr_i ? 1'b0 : (pend_q | rise);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7 / R3: a new pending state only follows a seen rising edge
  assert_set_needs_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !$past(pend_q)) |-> $past(line_i && !prev_q));

  generate
    if (HOLD_LEVEL) begin : g_hold_chk
      // R3: armed only while the line was high
      assert_arm_needs_level_R3: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $past(line_i));
    end
  endgenerate
endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             accept_mask_i,
  output logic [MSK_N-1:0] mask_o,
  output logic             ie_o,
  output logic             ser_o,
  output logic             pend_clr_o
);
  logic [MSK_N-1:0] mask_q;
  logic             ie_q, ser_q;
  logic             unused_bit5;

  assign unused_bit5 = wr_data_i[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_data_i[MW_MSK_EN]) mask_q <= wr_data_i[MSK_N-1:0];
      if (wr_en_i && wr_data_i[MW_SOE])    ser_q  <= wr_data_i[MW_SOD];
      if (accept_mask_i)  ie_q <= 1'b0;
      else if (di_i)      ie_q <= 1'b0;
      else if (ei_i)      ie_q <= 1'b1;
    end
  end

  assign pend_clr_o = wr_en_i & wr_data_i[MW_PCLR];
  assign mask_o     = mask_q;
  assign ie_o       = ie_q;
  assign ser_o      = ser_q;

  assert_mask_needs_qualifier_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(mask_q) |-> $past(wr_en_i && wr_data_i[MW_MSK_EN]));
  assert_enable_rise_from_ei_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(ie_q) |-> $past(ei_i));
  assert_accept_drops_enable_R11: assert property (@(posedge clk) disable iff (rst)
    accept_mask_i |=> !ie_q);
  assert_serial_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_q) |-> $past(wr_en_i && wr_data_i[MW_SOE]));
endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
  import irqc_pkg::*;
#(
  parameter int             VEC_W   = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] HI_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0] MID_VEC = 16'h0034,
  parameter logic [VEC_W-1:0] LO_VEC  = 16'h002C
) (
  input  logic [SRC_N-1:0] req_i,
  output logic             hit_o,
  output src_e             idx_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_o
);
  always_comb begin
    idx_o = SRC_EXT;
    for (int k = SRC_N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = src_e'(k);
    end
  end

  assign hit_o = |req_i;

  always_comb begin
    ext_o = 1'b0;
    case (idx_o)
      SRC_NMI: vec_o = NMI_VEC;
      SRC_HI:  vec_o = HI_VEC;
      SRC_MID: vec_o = MID_VEC;
      SRC_LO:  vec_o = LO_VEC;
      default: begin
        vec_o = '0;
        ext_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] HI_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0] MID_VEC = 16'h0034,
  parameter logic [VEC_W-1:0] LO_VEC  = 16'h002C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_line,
  input  logic             edge_line,
  input  logic             lvl_mid,
  input  logic             lvl_lo,
  input  logic             ext_line,
  input  logic             boundary,
  input  logic             ei_stb,
  input  logic             di_stb,
  input  logic             mwr_en,
  input  logic [CFG_W-1:0] mwr_data,
  input  logic             ser_in,
  output logic [CFG_W-1:0] status_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_ack_o,
  output logic             ser_out_o
);
  logic [MSK_N-1:0] mask;
  logic             ie, pend_clr;
  logic             nmi_arm, hi_pend;
  logic             clr_nmi, clr_hi;
  logic [SRC_N-1:0] req;
  logic             hit, accept, accept_mask, sel_ext;
  src_e             sel_idx;
  logic [VEC_W-1:0] sel_vec;
  logic             take_q, ext_q;
  logic [VEC_W-1:0] vec_q;

  irqc_edge_latch #(.HOLD_LEVEL(1'b1)) u_nmi_edge (
    .clk(clk), .rst(rst), .line_i(nmi_line), .clr_i(clr_nmi), .pend_o(nmi_arm));

  irqc_edge_latch #(.HOLD_LEVEL(1'b0)) u_hi_edge (
    .clk(clk), .rst(rst), .line_i(edge_line), .clr_i(clr_hi), .pend_o(hi_pend));

  irqc_mask_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(mwr_en), .wr_data_i(mwr_data),
    .ei_i(ei_stb), .di_i(di_stb), .accept_mask_i(accept_mask),
    .mask_o(mask), .ie_o(ie), .ser_o(ser_out_o), .pend_clr_o(pend_clr));

  always_comb begin
    req          = '0;
    req[SRC_NMI] = nmi_arm & nmi_line;
    req[SRC_HI]  = ie & hi_pend  & ~mask[2];
    req[SRC_MID] = ie & lvl_mid  & ~mask[1];
    req[SRC_LO]  = ie & lvl_lo   & ~mask[0];
    req[SRC_EXT] = ie & ext_line;
  end

  irqc_prio_sel #(
    .VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .HI_VEC(HI_VEC),
    .MID_VEC(MID_VEC), .LO_VEC(LO_VEC)
  ) u_sel (
    .req_i(req), .hit_o(hit), .idx_o(sel_idx), .vec_o(sel_vec), .ext_o(sel_ext));

  assign accept      = boundary & hit;
  assign accept_mask = accept & (sel_idx != SRC_NMI);
  assign clr_nmi     = accept & (sel_idx == SRC_NMI);
  assign clr_hi      = (accept & (sel_idx == SRC_HI)) | pend_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      ext_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      ext_q  <= accept & sel_ext;
      if (accept) vec_q <= sel_vec;
    end
  end

  assign take_o    = take_q;
  assign ext_ack_o = ext_q;
  assign vec_o     = vec_q;
  assign status_o  = {ser_in, hi_pend, lvl_mid, lvl_lo, ie, mask};

  assert_take_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary));
  assert_maskable_take_drops_enable_R11: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o != NMI_VEC) |-> !ie);
  assert_nmi_take_needs_level_R3: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == NMI_VEC) |-> $past(nmi_line));
  assert_ext_ack_form_R6: assert property (@(posedge clk) disable iff (rst)
    ext_ack_o |-> (take_o && vec_o == '0));
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_line = 0, edge_line = 0, lvl_mid = 0, lvl_lo = 0, ext_line = 0;
  logic boundary = 0, ei_stb = 0, di_stb = 0, mwr_en = 0, ser_in = 0;
  logic [7:0]  mwr_data = '0;
  logic [7:0]  status_o;
  logic        take_o, ext_ack_o, ser_out_o;
  logic [15:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst(rst), .nmi_line(nmi_line), .edge_line(edge_line),
    .lvl_mid(lvl_mid), .lvl_lo(lvl_lo), .ext_line(ext_line), .boundary(boundary),
    .ei_stb(ei_stb), .di_stb(di_stb), .mwr_en(mwr_en), .mwr_data(mwr_data),
    .ser_in(ser_in), .status_o(status_o), .take_o(take_o), .vec_o(vec_o),
    .ext_ack_o(ext_ack_o), .ser_out_o(ser_out_o));

  typedef struct packed {
    logic [2:0]  msk;
    logic        ie;
    logic        nmi, e75, l65, l55, ext;
    logic        take;
    logic [15:0] vec;
    logic        xa;
  } row_t;

  localparam int ROWS = 12;
  localparam row_t TBL [ROWS] = '{
    '{3'b111, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 16'h0024, 1'b0}, // R2 masked+disabled
    '{3'b000, 1'b1, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1, 16'h0024, 1'b0}, // R4 all five
    '{3'b000, 1'b1, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1, 16'h003C, 1'b0}, // R4 R5
    '{3'b000, 1'b1, 1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1, 16'h0034, 1'b0}, // R4 R5
    '{3'b000, 1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1, 16'h002C, 1'b0}, // R4 R5
    '{3'b000, 1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 16'h0000, 1'b1}, // R6
    '{3'b100, 1'b1, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1, 16'h0034, 1'b0}, // R10 edge masked
    '{3'b000, 1'b0, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0, 16'h0000, 1'b0}, // R11 disabled
    '{3'b001, 1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1, 16'h0000, 1'b1}, // R10 low masked
    '{3'b000, 1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 16'h0000, 1'b0}, // R4 none
    '{3'b000, 1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 16'h003C, 1'b0}, // R7 pulse only
    '{3'b010, 1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1, 16'h002C, 1'b0}  // R10 mid masked
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk); mwr_en = 1; mwr_data = d;
    @(negedge clk); mwr_en = 0; mwr_data = '0;
  endtask

  task automatic set_ie(input logic en);
    @(negedge clk); ei_stb = en; di_stb = !en;
    @(negedge clk); ei_stb = 0; di_stb = 0;
  endtask

  // strobe on one edge, outputs visible after the next
  task automatic strobe();
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
  endtask

  task automatic run_row(input int i, input row_t r);
    @(negedge clk);
    mwr_en = 1; mwr_data = {3'b000, 1'b1, 1'b1, r.msk};
    ei_stb = r.ie; di_stb = !r.ie;
    @(negedge clk);
    mwr_en = 0; mwr_data = '0; ei_stb = 0; di_stb = 0;
    nmi_line = r.nmi; edge_line = r.e75; lvl_mid = r.l65; lvl_lo = r.l55; ext_line = r.ext;
    @(negedge clk); edge_line = 0;
    strobe();
    chk($sformatf("table row %0d take", i), {31'd0, take_o}, {31'd0, r.take});
    if (r.take) begin
      chk($sformatf("table row %0d vector", i), {16'd0, vec_o}, {16'd0, r.vec});
      chk($sformatf("table row %0d ext flag", i), {31'd0, ext_ack_o}, {31'd0, r.xa});
    end
    nmi_line = 0; lvl_mid = 0; lvl_lo = 0; ext_line = 0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 R13: reset state
    chk("R1 status after reset", {24'd0, status_o}, 32'h07);
    chk("R1 take after reset", {31'd0, take_o}, 0);
    chk("R1 ser_out after reset", {31'd0, ser_out_o}, 0);

    // R13: live pins and serial input
    lvl_lo = 1; lvl_mid = 1; ser_in = 1;
    @(negedge clk);
    chk("R13 status pins", {24'd0, status_o}, 32'hB7);
    lvl_lo = 0; lvl_mid = 0; ser_in = 0;
    cfg_write(8'h0D);
    chk("R13 R10 mask field", {24'd0, status_o}, 32'h05);

    // table of request mixes (R2 R4 R5 R6 R10 R11)
    for (int i = 0; i < ROWS; i++) run_row(i, TBL[i]);

    // R2 R3: non-maskable held high, re-armed by a new edge
    @(negedge clk); nmi_line = 1;
    strobe();
    chk("R2 nmi take", {31'd0, take_o}, 1);
    chk("R2 nmi vector", {16'd0, vec_o}, 32'h0024);
    @(negedge clk);
    chk("R2 take is one cycle", {31'd0, take_o}, 0);
    strobe();
    chk("R3 held line not retaken", {31'd0, take_o}, 0);
    @(negedge clk); nmi_line = 0;
    @(negedge clk); nmi_line = 1;
    strobe();
    chk("R3 new edge retaken", {31'd0, take_o}, 1);
    @(negedge clk); nmi_line = 0;
    @(negedge clk); nmi_line = 1;
    @(negedge clk); nmi_line = 0;
    strobe();
    chk("R3 pulse gone before strobe", {31'd0, take_o}, 0);

    // R7: masked edge remembered, taken after unmask
    cfg_write(8'h1C);          // mask edge source, clear pending
    set_ie(1);
    @(negedge clk); edge_line = 1;
    @(negedge clk); edge_line = 0;
    @(negedge clk);
    chk("R7 pending while masked", {31'd0, status_o[6]}, 1);
    strobe();
    chk("R7 masked not taken", {31'd0, take_o}, 0);
    cfg_write(8'h08);
    strobe();
    chk("R7 taken after unmask", {16'd0, vec_o}, 32'h003C);
    chk("R7 taken pulse", {31'd0, take_o}, 1);
    chk("R7 pending cleared by service", {31'd0, status_o[6]}, 0);
    chk("R11 enable cleared on accept", {31'd0, status_o[3]}, 0);
    @(negedge clk); edge_line = 1;
    set_ie(1);
    strobe();
    chk("R7 rise while held taken", {31'd0, take_o}, 1);
    set_ie(1);
    strobe();
    chk("R7 held line no new pending", {31'd0, take_o}, 0);
    @(negedge clk); edge_line = 0;

    // R8: clear via write; masks untouched without qualifier (R10)
    @(negedge clk); edge_line = 1;
    @(negedge clk); edge_line = 0;
    cfg_write(8'h17);
    chk("R8 pending cleared by write", {31'd0, status_o[6]}, 0);
    chk("R10 masks unchanged without bit3", {29'd0, status_o[2:0]}, 0);
    set_ie(1);
    strobe();
    chk("R8 cleared edge not taken", {31'd0, take_o}, 0);

    // R9: level pulse gone before strobe
    @(negedge clk); lvl_lo = 1;
    @(negedge clk); lvl_lo = 0;
    strobe();
    chk("R9 dropped level not taken", {31'd0, take_o}, 0);

    // R11: enable flag strobes
    set_ie(0);
    chk("R11 di clears", {31'd0, status_o[3]}, 0);
    set_ie(1);
    chk("R11 ei sets", {31'd0, status_o[3]}, 1);

    // R12: serial output bit
    cfg_write(8'hC0);
    chk("R12 serial set", {31'd0, ser_out_o}, 1);
    cfg_write(8'h80);
    chk("R12 serial held without enable", {31'd0, ser_out_o}, 1);
    cfg_write(8'h40);
    chk("R12 serial cleared", {31'd0, ser_out_o}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule